// File: doc/BRIEF.md
# Registered narrow-to-wide bus exchanger

This block links a narrow A port with a wide B bus made of two narrow halves, the upper lane B1 and the lower lane B2. Going from A towards B, it collects two narrow words that arrive one after the other and presents them together as one wide word. The first word is held in a capture stage and then moved to B1. On that same edge, the second word is taken straight from A into B2.

Going from B towards A, each lane has its own capture register. A registered lane pick chooses which stored lane is shown on A. All storage, the lane pick and both active-low port drive controls are registers on one rising-edge clock, so a change of bus direction only happens at an edge. Each group of storage registers is gated by its own active-low load enable.

Three-state pins appear as a value output plus a drive-enable output, and the input pins are separate ports. The value outputs always carry the stored data, even when their drive enable is off.

Top module: `bus_exchanger`

## Requirements
- R1: A synchronous active-high `rst` makes every value output (`a_q`, `b1_q`, `b2_q`) zero and every drive enable (`a_en`, `b1_en`, `b2_en`) 0 at the first edge where it is high.
- R2: The A capture stage loads `a_in` on an edge only when `wr_stage_n` is 0. Otherwise it keeps its word.
- R3: On an edge with `wr_pair_n` = 0, `b1_q` takes the word that the A capture stage held before that edge, and `b2_q` takes `a_in`.
- R4: If word X is on `a_in` at an edge with `wr_stage_n` = 0, and word Y is on `a_in` at the next edge with `wr_pair_n` = 0, then after that edge `b1_q` = X and `b2_q` = Y.
- R5: When `wr_stage_n` and `wr_pair_n` are both 0 on the same edge, `b1_q` gets the capture stage's old word. The capture stage takes the new `a_in`, and a later pair load moves that word to `b1_q`.
- R6: With `wr_pair_n` = 1, `b1_q` and `b2_q` keep their values across edges, whatever `a_in` does.
- R7: The B1 return register loads `b1_in` only on an edge with `rd_b1_n` = 0. The B2 return register loads `b2_in` only on an edge with `rd_b2_n` = 0. A load enable held at 1 keeps that register's content.
- R8: `pick_b1` is sampled at the edge. After an edge where it was 1, `a_q` shows the B1 return register. After an edge where it was 0, `a_q` shows the B2 return register. A change of `pick_b1` between edges does not alter `a_q`.
- R9: `a_en` equals the inverse of `a_drive_n` sampled at the last edge. `b1_en` and `b2_en` both equal the inverse of `b_drive_n` sampled at the last edge. Between edges the enables do not change.
- R10: `b1_q`, `b2_q` and `a_q` carry the stored values whether or not their drive enables are on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for all state |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | WIDTH | Narrow A-side input word |
| b1_in | input | WIDTH | Upper-lane B input word |
| b2_in | input | WIDTH | Lower-lane B input word |
| wr_stage_n | input | 1 | Active-low load for the A capture stage |
| wr_pair_n | input | 1 | Active-low pair load: capture stage to B1, A to B2 |
| rd_b1_n | input | 1 | Active-low load for the B1 return register |
| rd_b2_n | input | 1 | Active-low load for the B2 return register |
| pick_b1 | input | 1 | Lane pick for A, 1 = B1 lane, 0 = B2 lane (registered) |
| a_drive_n | input | 1 | Active-low A drive request (registered) |
| b_drive_n | input | 1 | Active-low B drive request (registered) |
| a_q | output | WIDTH | A output value |
| a_en | output | 1 | A drive enable |
| b1_q | output | WIDTH | B1 output value |
| b1_en | output | 1 | B1 drive enable |
| b2_q | output | WIDTH | B2 output value |
| b2_en | output | 1 | B2 drive enable |

## Verification
A load into the capture stage and a pair load can fall on the same edge. In that case B1 must receive the old staged word while the stage takes the new one. The bench provokes this by staging word P, then asserting both loads with Q on A. It then expects P on B1 and Q on B2, and after a further pair-only load with R on A it expects Q on B1 and R on B2. A lane-pick change together with a fresh return capture is also exercised, and A is judged to show the newly captured word of the newly picked lane one edge later.

// File: rtl/bx_pkg.sv
package bx_pkg;
   typedef enum logic {
      PICK_LANE2 = 1'b0,
      PICK_LANE1 = 1'b1
   } pick_t;

   localparam int NUM_LANES = 2;
endpackage

// File: rtl/bx_cereg.sv
module bx_cereg #(
   parameter int W = 1,
   parameter logic [W-1:0] INIT = '0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         en_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk) begin
      if (rst)
         q <= INIT;
      else if (!en_n)
         q <= d;
   end
endmodule

// File: rtl/bx_pack_path.sv
module bx_pack_path #(
   parameter int W = 12
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] a_in,
   input  logic         wr_stage_n,
   input  logic         wr_pair_n,
   output logic [W-1:0] b1_word,
   output logic [W-1:0] b2_word
);
   logic [W-1:0] stage_q;

   bx_cereg #(.W(W)) u_stage (
      .clk(clk), .rst(rst), .en_n(wr_stage_n), .d(a_in), .q(stage_q)
   );
   bx_cereg #(.W(W)) u_hi (
      .clk(clk), .rst(rst), .en_n(wr_pair_n), .d(stage_q), .q(b1_word)
   );
   bx_cereg #(.W(W)) u_lo (
      .clk(clk), .rst(rst), .en_n(wr_pair_n), .d(a_in), .q(b2_word)
   );

   // R3
   pair_lo_chk: assert property (@(posedge clk) disable iff (rst)
      !wr_pair_n |=> (b2_word == $past(a_in)));
   // R3
   pair_hi_chk: assert property (@(posedge clk) disable iff (rst)
      !wr_pair_n |=> (b1_word == $past(stage_q)));
   // R6
   pair_hold_chk: assert property (@(posedge clk) disable iff (rst)
      wr_pair_n |=> ($stable(b1_word) && $stable(b2_word)));
   // R2
   stage_hold_chk: assert property (@(posedge clk) disable iff (rst)
      wr_stage_n |=> $stable(stage_q));
endmodule

// File: rtl/bx_return_path.sv
module bx_return_path
   import bx_pkg::*;
#(
   parameter int W = 12
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] b1_in,
   input  logic [W-1:0] b2_in,
   input  logic         rd_b1_n,
   input  logic         rd_b2_n,
   input  logic         pick_b1,
   output logic [W-1:0] a_word
);
   logic [W-1:0] lane_d  [NUM_LANES];
   logic         lane_en [NUM_LANES];
   logic [W-1:0] lane_q  [NUM_LANES];
   logic         pick_raw;
   pick_t        pick_q;

   assign lane_d[0]  = b1_in;
   assign lane_d[1]  = b2_in;
   assign lane_en[0] = rd_b1_n;
   assign lane_en[1] = rd_b2_n;

   for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
      bx_cereg #(.W(W)) u_ret (
         .clk(clk), .rst(rst), .en_n(lane_en[g]), .d(lane_d[g]), .q(lane_q[g])
      );
   end

   bx_cereg #(.W(1)) u_pick (
      .clk(clk), .rst(rst), .en_n(1'b0), .d(pick_b1), .q(pick_raw)
   );
   assign pick_q = pick_t'(pick_raw);

   always_comb begin
      if (pick_q == PICK_LANE1)
         a_word = lane_q[0];
      else
         a_word = lane_q[1];
   end

   // R8
   pick_follow_chk: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (a_word == ($past(pick_b1) ? lane_q[0] : lane_q[1])));
   // R7
   ret1_hold_chk: assert property (@(posedge clk) disable iff (rst)
      rd_b1_n |=> $stable(lane_q[0]));
   // R7
   ret2_load_chk: assert property (@(posedge clk) disable iff (rst)
      !rd_b2_n |=> (lane_q[1] == $past(b2_in)));
endmodule

// File: rtl/bx_drive_ctl.sv
module bx_drive_ctl (
   input  logic clk,
   input  logic rst,
   input  logic a_drive_n,
   input  logic b_drive_n,
   output logic a_en,
   output logic b_en
);
   logic a_off_q;
   logic b_off_q;

   bx_cereg #(.W(1), .INIT(1'b1)) u_a (
      .clk(clk), .rst(rst), .en_n(1'b0), .d(a_drive_n), .q(a_off_q)
   );
   bx_cereg #(.W(1), .INIT(1'b1)) u_b (
      .clk(clk), .rst(rst), .en_n(1'b0), .d(b_drive_n), .q(b_off_q)
   );

   assign a_en = ~a_off_q;
   assign b_en = ~b_off_q;

   // R9
   a_drive_chk: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (a_en == !$past(a_drive_n)));
   // R9
   b_drive_chk: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (b_en == !$past(b_drive_n)));
endmodule

// File: rtl/bus_exchanger.sv
module bus_exchanger #(
   parameter int WIDTH = 12
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] a_in,
   input  logic [WIDTH-1:0] b1_in,
   input  logic [WIDTH-1:0] b2_in,
   input  logic             wr_stage_n,
   input  logic             wr_pair_n,
   input  logic             rd_b1_n,
   input  logic             rd_b2_n,
   input  logic             pick_b1,
   input  logic             a_drive_n,
   input  logic             b_drive_n,
   output logic [WIDTH-1:0] a_q,
   output logic             a_en,
   output logic [WIDTH-1:0] b1_q,
   output logic             b1_en,
   output logic [WIDTH-1:0] b2_q,
   output logic             b2_en
);
   localparam int WIDE = 2 * WIDTH;

   logic            b_en;
   logic [WIDE-1:0] wide_word;

   if (WIDTH < 1) begin : g_bad_width
      $error("bus_exchanger: WIDTH must be at least 1");
   end

   bx_pack_path #(.W(WIDTH)) u_pack (
      .clk(clk), .rst(rst), .a_in(a_in),
      .wr_stage_n(wr_stage_n), .wr_pair_n(wr_pair_n),
      .b1_word(wide_word[WIDE-1:WIDTH]), .b2_word(wide_word[WIDTH-1:0])
   );

   bx_return_path #(.W(WIDTH)) u_ret (
      .clk(clk), .rst(rst), .b1_in(b1_in), .b2_in(b2_in),
      .rd_b1_n(rd_b1_n), .rd_b2_n(rd_b2_n), .pick_b1(pick_b1),
      .a_word(a_q)
   );

   bx_drive_ctl u_drv (
      .clk(clk), .rst(rst), .a_drive_n(a_drive_n), .b_drive_n(b_drive_n),
      .a_en(a_en), .b_en(b_en)
   );

   assign b1_q  = wide_word[WIDE-1:WIDTH];
   assign b2_q  = wide_word[WIDTH-1:0];
   assign b1_en = b_en;
   assign b2_en = b_en;

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (a_q == '0 && b1_q == '0 && b2_q == '0 && !a_en && !b_en));
endmodule

// File: tb/bus_exchanger_test.sv
module bus_exchanger_test;
   localparam int W = 12;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [W-1:0] a_in = '0, b1_in = '0, b2_in = '0;
   logic         wr_stage_n = 1'b1, wr_pair_n = 1'b1;
   logic         rd_b1_n = 1'b1, rd_b2_n = 1'b1;
   logic         pick_b1 = 1'b0;
   logic         a_drive_n = 1'b1, b_drive_n = 1'b1;
   logic [W-1:0] a_q, b1_q, b2_q;
   logic         a_en, b1_en, b2_en;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   bus_exchanger #(.WIDTH(W)) uut (
      .clk(clk), .rst(rst), .a_in(a_in), .b1_in(b1_in), .b2_in(b2_in),
      .wr_stage_n(wr_stage_n), .wr_pair_n(wr_pair_n),
      .rd_b1_n(rd_b1_n), .rd_b2_n(rd_b2_n), .pick_b1(pick_b1),
      .a_drive_n(a_drive_n), .b_drive_n(b_drive_n),
      .a_q(a_q), .a_en(a_en), .b1_q(b1_q), .b1_en(b1_en),
      .b2_q(b2_q), .b2_en(b2_en)
   );

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   function automatic logic [W-1:0] word(input int i, input int salt);
      return W'((i * 273 + salt * 1361) ^ (salt * 7));
   endfunction

   initial begin
      logic [W-1:0] x, y, z;
      tick();
      tick();
      // R1: reset state
      chk("R1 a_q", a_q, '0);
      chk("R1 b1_q", b1_q, '0);
      chk("R1 b2_q", b2_q, '0);
      chk("R1 a_en", W'(a_en), '0);
      chk("R1 b1_en", W'(b1_en), '0);
      chk("R1 b2_en", W'(b2_en), '0);
      rst = 1'b0;

      // R4 and R6: sweep of word pairs
      for (int i = 0; i < 16; i++) begin
         x = word(i, 1);
         y = word(i, 2) ^ 12'hA5A;
         a_in = x; wr_stage_n = 1'b0; wr_pair_n = 1'b1;
         tick();
         a_in = y; wr_stage_n = 1'b1; wr_pair_n = 1'b0;
         tick();
         chk("R4 b1_q first word", b1_q, x);
         chk("R4 b2_q second word", b2_q, y);
         a_in = ~y; wr_pair_n = 1'b1;
         tick();
         tick();
         chk("R6 b1_q held", b1_q, x);
         chk("R6 b2_q held", b2_q, y);
      end

      // R2: stage keeps its word while wr_stage_n is high
      a_in = 12'h123; wr_stage_n = 1'b0;
      tick();
      wr_stage_n = 1'b1; a_in = 12'hFED;
      tick();
      a_in = 12'h456; wr_pair_n = 1'b0;
      tick();
      chk("R2 stage held", b1_q, 12'h123);
      chk("R3 b2 from a_in", b2_q, 12'h456);
      wr_pair_n = 1'b1;

      // R5: stage load and pair load on the same edge
      a_in = 12'h0AB; wr_stage_n = 1'b0;
      tick();
      a_in = 12'h0CD; wr_stage_n = 1'b0; wr_pair_n = 1'b0;
      tick();
      chk("R5 b1 old stage", b1_q, 12'h0AB);
      chk("R5 b2 new a", b2_q, 12'h0CD);
      a_in = 12'h0EF; wr_stage_n = 1'b1; wr_pair_n = 1'b0;
      tick();
      chk("R5 b1 later", b1_q, 12'h0CD);
      chk("R3 b2 later", b2_q, 12'h0EF);
      wr_pair_n = 1'b1;

      // R7 and R8: return path sweep
      for (int i = 0; i < 16; i++) begin
         x = word(i, 3);
         y = word(i, 4) ^ 12'h3C3;
         b1_in = x; b2_in = y; rd_b1_n = 1'b0; rd_b2_n = 1'b0; pick_b1 = 1'b1;
         tick();
         chk("R8 a_q picks b1", a_q, x);
         rd_b1_n = 1'b1; rd_b2_n = 1'b1; b1_in = ~x; b2_in = ~y; pick_b1 = 1'b0;
         #1;
         chk("R8 pick not yet", a_q, x);
         tick();
         chk("R8 a_q picks b2", a_q, y);
         chk("R7 b2 held", a_q, y);
         pick_b1 = 1'b1;
         tick();
         chk("R7 b1 held", a_q, x);
      end

      // R7: one lane loads, the other keeps
      z = 12'h777;
      b1_in = z; rd_b1_n = 1'b0; b2_in = 12'h999; rd_b2_n = 1'b1; pick_b1 = 1'b0;
      tick();
      rd_b1_n = 1'b1;
      chk("R7 b2 kept while b1 loads", a_q, y);
      pick_b1 = 1'b1;
      tick();
      chk("R7 b1 loaded", a_q, z);

      // R8: pick change together with a fresh capture
      b2_in = 12'h5E5; rd_b2_n = 1'b0; pick_b1 = 1'b0;
      tick();
      rd_b2_n = 1'b1;
      chk("R8 new lane new word", a_q, 12'h5E5);

      // R9: drive enables for all request combinations
      for (int k = 0; k < 4; k++) begin
         logic pa, pb;
         pa = a_en; pb = b1_en;
         a_drive_n = k[0]; b_drive_n = k[1];
         #1;
         chk("R9 a_en waits for edge", W'(a_en), W'(pa));
         chk("R9 b_en waits for edge", W'(b1_en), W'(pb));
         tick();
         chk("R9 a_en", W'(a_en), W'(!k[0]));
         chk("R9 b1_en", W'(b1_en), W'(!k[1]));
         chk("R9 b2_en", W'(b2_en), W'(!k[1]));
      end

      // R10: values shown while drive is off
      a_drive_n = 1'b1; b_drive_n = 1'b1;
      a_in = 12'h31C; wr_stage_n = 1'b0;
      tick();
      a_in = 12'h42D; wr_stage_n = 1'b1; wr_pair_n = 1'b0;
      tick();
      wr_pair_n = 1'b1;
      chk("R10 b1 enable off", W'(b1_en), '0);
      chk("R10 b1 value", b1_q, 12'h31C);
      chk("R10 b2 value", b2_q, 12'h42D);
      chk("R10 a value", a_q, 12'h5E5);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule